// File: doc/BRIEF.md
# Raster LCD Timing Generator

This block produces every timing signal a raster LCD panel needs. It turns the core clock into a slower pixel clock and walks each line through four segments in order: sync pulse, back porch, active pixels and front porch. The frame goes through the same four segments, counted in lines. It drives a line clock that is active during each horizontal sync pulse, a frame clock that is active during the vertical sync lines, and a data enable that is high over the visible area. It also gives one-cycle strobes at the start of each line and each frame. Each of the three clocks has its own polarity bit.

Software programs the block through a simple write port. `wr_sel` picks one of five 32-bit words and `wr_data` carries its contents. Active width is programmed in units of 16 pixels. The line count is split: its low ten bits are in the vertical word and its top bit is in the polarity word. While the raster runs, written values are held in shadow registers. They are copied into the working set only at the next frame boundary, so a frame that has already started keeps the timing it began with.

Two state machines sequence the raster. The horizontal machine has the states H_IDLE, H_SYNC, H_BACK, H_ACT and H_FRONT. Its transitions are:
- start: H_IDLE to H_SYNC on the first pixel step after running begins.
- sync done: H_SYNC to H_BACK.
- back done: H_BACK to H_ACT.
- active done: H_ACT to H_FRONT.
- line wrap: H_FRONT to H_SYNC.
- stop: any state to H_IDLE.

The vertical machine has the states V_IDLE, V_SYNC, V_BACK, V_ACT and V_FRONT. It steps only on a start or a line wrap. Its transitions are:
- start: V_IDLE to V_SYNC.
- vsync done: V_SYNC to V_BACK.
- vback done: V_BACK to V_ACT.
- vactive done: V_ACT to V_FRONT.
- frame wrap: V_FRONT to V_SYNC.
- stop: any state to V_IDLE.

Top module: `lcd_raster_timer`

## Requirements
- R1: The pixel clock period is D core cycles, where D is the divisor field at bits 15:8 of the control word (wr_sel 0). A divisor value of 0 or 1 gives D = 2. In each period the uninverted pixel clock is high for floor(D/2) cycles.
- R2: The horizontal word (wr_sel 2) holds the following fields:
  - back porch at bits 31:24;
  - front porch at bits 23:16;
  - sync width at bits 15:10;
  - the low six bits of the width code at bits 9:4.

  Each line is hsw+1 sync pixels, then hbp+1 back-porch pixels, then 16*(width code+1) active pixels, then hfp+1 front-porch pixels. The line clock is active only during the sync pixels.
- R3: The vertical word (wr_sel 3) holds back porch at 31:24, front porch at 23:16, sync width at 15:10 and line code bits 9:0. A frame is vsw+1 sync lines, then vbp+1 back-porch lines, then line code+1 active lines, then vfp+1 front-porch lines. The frame clock is active only during the sync lines, and every frame begins with them.
- R4: Data enable is high exactly during the active pixels of the active lines.
- R5: With EXTENDED set, bit 3 of the horizontal word is bit 6 of the width code, which allows 2048 pixels. Bit 26 of the polarity word (wr_sel 4) is bit 10 of the line code. With EXTENDED clear, both bits read as zero.
- R6: In the polarity word, bit 22 inverts the pixel clock, bit 21 inverts the line clock and bit 20 inverts the frame clock. An inverted output rests at 1 when inactive, and this includes while the raster is stopped.
- R7: When both bit 25 (edge control enable) and bit 24 (edge select) of the polarity word are set, the timing advances on the falling pixel-clock edge, and the uninverted pixel clock is low in the cycle of a frame strobe. Otherwise the timing advances on the rising edge, and the pixel clock is high in that cycle. Bit 24 alone changes nothing.
- R8: The raster runs only while bit 0 of the control word and bit 0 of the raster-enable word (wr_sel 1) are both 1. Otherwise, one cycle later, the outputs rest at their inactive levels and no strobes occur. When running resumes, the raster restarts at the beginning of a frame.
- R9: `line_start_o` pulses for one core cycle as each line's sync begins. `frame_start_o` pulses for one core cycle as each frame begins, always in the same cycle as a line strobe.
- R10: While the raster runs, words that have been written take effect at the next frame start. While it is stopped, they take effect at once.
- R11: After reset every register is zero and every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | core clock |
| rst_n | input | 1 | asynchronous reset, active low |
| wr_en | input | 1 | write strobe for one register word |
| wr_sel | input | 3 | word select: 0 control, 1 raster enable, 2 horizontal, 3 vertical, 4 polarity |
| wr_data | input | 32 | word contents |
| pix_clk_o | output | 1 | pixel clock |
| line_clk_o | output | 1 | line clock (horizontal sync) |
| frame_clk_o | output | 1 | frame clock (vertical sync) |
| de_o | output | 1 | active data enable |
| line_start_o | output | 1 | one-cycle line start strobe |
| frame_start_o | output | 1 | one-cycle frame start strobe |

## Verification
Two functions can meet in one cycle.

The first pair is the frame boundary and the line boundary. Every frame start is also a line start, so both strobes must rise together exactly once per frame. The bench counts both strobes over whole frames and checks that they coincide.

The second pair is a register write and a frame that is still in progress. The bench writes a new front porch in the cycle right after a frame strobe. It then checks that the running frame keeps its old length and that the following frame has the new length.

// File: rtl/lcd_rt_pkg.sv
package lcd_rt_pkg;

    localparam int WORD_W  = 32;
    localparam int SEL_W   = 3;
    localparam int DIVF_W  = 8;
    localparam int PORCH_W = 8;
    localparam int SYNC_W  = 6;
    localparam int PPL_W   = 7;
    localparam int LPP_W   = 11;
    localparam int CNT_W   = 12;

    localparam logic [SEL_W-1:0] SEL_CTRL  = 3'd0;
    localparam logic [SEL_W-1:0] SEL_RUN   = 3'd1;
    localparam logic [SEL_W-1:0] SEL_HORIZ = 3'd2;
    localparam logic [SEL_W-1:0] SEL_VERT  = 3'd3;
    localparam logic [SEL_W-1:0] SEL_POL   = 3'd4;

    typedef enum logic [2:0] {
        H_IDLE, H_SYNC, H_BACK, H_ACT, H_FRONT
    } hstate_t;

    typedef enum logic [2:0] {
        V_IDLE, V_SYNC, V_BACK, V_ACT, V_FRONT
    } vstate_t;

    typedef struct packed {
        logic [DIVF_W-1:0]  div;
        logic [PORCH_W-1:0] hbp;
        logic [PORCH_W-1:0] hfp;
        logic [SYNC_W-1:0]  hsw;
        logic [PPL_W-1:0]   ppl;
        logic [PORCH_W-1:0] vbp;
        logic [PORCH_W-1:0] vfp;
        logic [SYNC_W-1:0]  vsw;
        logic [LPP_W-1:0]   lpp;
        logic               inv_pix;
        logic               inv_line;
        logic               inv_frame;
        logic               edge_ctl;
        logic               edge_sel;
    } timing_cfg_t;

endpackage

// File: rtl/lcd_rt_regs.sv
module lcd_rt_regs
    import lcd_rt_pkg::*;
#(
    parameter bit EXTENDED = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              load,
    output logic              run,
    output timing_cfg_t       act
);

    timing_cfg_t shd;
    logic        mode_q;
    logic        en_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shd    <= '0;
            mode_q <= 1'b0;
            en_q   <= 1'b0;
        end else if (wr_en) begin
            case (wr_sel)
                SEL_CTRL: begin
                    shd.div <= wr_data[15:8];
                    mode_q  <= wr_data[0];
                end
                SEL_RUN: en_q <= wr_data[0];
                SEL_HORIZ: begin
                    shd.hbp <= wr_data[31:24];
                    shd.hfp <= wr_data[23:16];
                    shd.hsw <= wr_data[15:10];
                    shd.ppl <= {EXTENDED & wr_data[3], wr_data[9:4]};
                end
                SEL_VERT: begin
                    shd.vbp      <= wr_data[31:24];
                    shd.vfp      <= wr_data[23:16];
                    shd.vsw      <= wr_data[15:10];
                    shd.lpp[9:0] <= wr_data[9:0];
                end
                SEL_POL: begin
                    shd.lpp[10]   <= EXTENDED & wr_data[26];
                    shd.edge_ctl  <= wr_data[25];
                    shd.edge_sel  <= wr_data[24];
                    shd.inv_pix   <= wr_data[22];
                    shd.inv_line  <= wr_data[21];
                    shd.inv_frame <= wr_data[20];
                end
                default: ;
            endcase
        end
    end

    assign run = mode_q & en_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act <= '0;
        end else if (!run || load) begin
            act <= shd;
        end
    end

endmodule

// File: rtl/lcd_rt_clkdiv.sv
module lcd_rt_clkdiv
    import lcd_rt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              late,
    input  logic [DIVF_W-1:0] div,
    output logic              pix_q,
    output logic              adv
);

    logic [DIVF_W-1:0] dcnt;
    logic [DIVF_W-1:0] div_eff;
    logic [DIVF_W-1:0] half;
    logic [DIVF_W-1:0] dnext;
    logic              wrap;

    always_comb begin
        div_eff = (div < DIVF_W'(2)) ? DIVF_W'(2) : div;
        half    = div_eff >> 1;
        wrap    = (dcnt >= div_eff - DIVF_W'(1));
        dnext   = wrap ? '0 : dcnt + DIVF_W'(1);
        adv     = run && (late ? (dcnt == half - DIVF_W'(1)) : wrap);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dcnt  <= '0;
            pix_q <= 1'b0;
        end else if (!run) begin
            dcnt  <= '0;
            pix_q <= 1'b0;
        end else begin
            dcnt  <= dnext;
            pix_q <= (dnext < half);
        end
    end

endmodule

// File: rtl/lcd_rt_hseq.sv
module lcd_rt_hseq
    import lcd_rt_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic               adv,
    input  logic [SYNC_W-1:0]  hsw,
    input  logic [PORCH_W-1:0] hbp,
    input  logic [PORCH_W-1:0] hfp,
    input  logic [PPL_W-1:0]   ppl,
    output hstate_t            state,
    output logic               begin_ev,
    output logic               line_wrap,
    output logic               line_start_q
);

    hstate_t          nxt;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cnt_nxt;
    logic [CNT_W-1:0] act_last;
    logic             seg_end;

    always_comb begin
        act_last = CNT_W'({ppl, 4'hF});
        nxt      = state;
        seg_end  = 1'b0;
        unique case (state)
            H_IDLE:  nxt = H_SYNC;
            H_SYNC: begin
                seg_end = (cnt == CNT_W'(hsw));
                if (seg_end) nxt = H_BACK;
            end
            H_BACK: begin
                seg_end = (cnt == CNT_W'(hbp));
                if (seg_end) nxt = H_ACT;
            end
            H_ACT: begin
                seg_end = (cnt == act_last);
                if (seg_end) nxt = H_FRONT;
            end
            H_FRONT: begin
                seg_end = (cnt == CNT_W'(hfp));
                if (seg_end) nxt = H_SYNC;
            end
            default: nxt = H_IDLE;
        endcase
        cnt_nxt   = (seg_end || state == H_IDLE) ? '0 : cnt + CNT_W'(1);
        begin_ev  = adv && (state == H_IDLE);
        line_wrap = adv && (state == H_FRONT) && seg_end;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= H_IDLE;
            cnt   <= '0;
        end else if (!run) begin
            state <= H_IDLE;
            cnt   <= '0;
        end else if (adv) begin
            state <= nxt;
            cnt   <= cnt_nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_start_q <= 1'b0;
        end else begin
            line_start_q <= run && (begin_ev || line_wrap);
        end
    end

endmodule

// File: rtl/lcd_rt_vseq.sv
module lcd_rt_vseq
    import lcd_rt_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic               begin_ev,
    input  logic               line_wrap,
    input  logic [SYNC_W-1:0]  vsw,
    input  logic [PORCH_W-1:0] vbp,
    input  logic [PORCH_W-1:0] vfp,
    input  logic [LPP_W-1:0]   lpp,
    output vstate_t            state,
    output logic               frame_bound,
    output logic               frame_start_q
);

    vstate_t          nxt;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cnt_nxt;
    logic             seg_end;
    logic             step;

    always_comb begin
        nxt     = state;
        seg_end = 1'b0;
        step    = begin_ev || line_wrap;
        unique case (state)
            V_IDLE:  nxt = V_SYNC;
            V_SYNC: begin
                seg_end = (cnt == CNT_W'(vsw));
                if (seg_end) nxt = V_BACK;
            end
            V_BACK: begin
                seg_end = (cnt == CNT_W'(vbp));
                if (seg_end) nxt = V_ACT;
            end
            V_ACT: begin
                seg_end = (cnt == CNT_W'(lpp));
                if (seg_end) nxt = V_FRONT;
            end
            V_FRONT: begin
                seg_end = (cnt == CNT_W'(vfp));
                if (seg_end) nxt = V_SYNC;
            end
            default: nxt = V_IDLE;
        endcase
        cnt_nxt     = (seg_end || state == V_IDLE) ? '0 : cnt + CNT_W'(1);
        frame_bound = begin_ev || (line_wrap && (state == V_FRONT) && seg_end);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= V_IDLE;
            cnt   <= '0;
        end else if (!run) begin
            state <= V_IDLE;
            cnt   <= '0;
        end else if (step) begin
            state <= nxt;
            cnt   <= cnt_nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frame_start_q <= 1'b0;
        end else begin
            frame_start_q <= run && frame_bound;
        end
    end

endmodule

// File: rtl/lcd_raster_timer.sv
module lcd_raster_timer
    import lcd_rt_pkg::*;
#(
    parameter bit EXTENDED = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [WORD_W-1:0] wr_data,
    output logic              pix_clk_o,
    output logic              line_clk_o,
    output logic              frame_clk_o,
    output logic              de_o,
    output logic              line_start_o,
    output logic              frame_start_o
);

    timing_cfg_t cfg;
    logic        run;
    logic        frame_bound;
    logic        pix_q;
    logic        adv;
    logic        begin_ev;
    logic        line_wrap;
    hstate_t     h_state;
    vstate_t     v_state;

    lcd_rt_regs #(.EXTENDED(EXTENDED)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .load    (frame_bound),
        .run     (run),
        .act     (cfg)
    );

    lcd_rt_clkdiv u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .late  (cfg.edge_ctl & cfg.edge_sel),
        .div   (cfg.div),
        .pix_q (pix_q),
        .adv   (adv)
    );

    lcd_rt_hseq u_hseq (
        .clk          (clk),
        .rst_n        (rst_n),
        .run          (run),
        .adv          (adv),
        .hsw          (cfg.hsw),
        .hbp          (cfg.hbp),
        .hfp          (cfg.hfp),
        .ppl          (cfg.ppl),
        .state        (h_state),
        .begin_ev     (begin_ev),
        .line_wrap    (line_wrap),
        .line_start_q (line_start_o)
    );

    lcd_rt_vseq u_vseq (
        .clk           (clk),
        .rst_n         (rst_n),
        .run           (run),
        .begin_ev      (begin_ev),
        .line_wrap     (line_wrap),
        .vsw           (cfg.vsw),
        .vbp           (cfg.vbp),
        .vfp           (cfg.vfp),
        .lpp           (cfg.lpp),
        .state         (v_state),
        .frame_bound   (frame_bound),
        .frame_start_q (frame_start_o)
    );

    always_comb begin
        pix_clk_o   = pix_q ^ cfg.inv_pix;
        line_clk_o  = (h_state == H_SYNC) ^ cfg.inv_line;
        frame_clk_o = (v_state == V_SYNC) ^ cfg.inv_frame;
        de_o        = (h_state == H_ACT) && (v_state == V_ACT);
    end

endmodule

// File: rtl/lcd_raster_timer_chk.sv
module lcd_raster_timer_chk
    import lcd_rt_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        run,
    input logic        load,
    input hstate_t     hs,
    input vstate_t     vs,
    input logic        de_o,
    input logic        line_start_o,
    input logic        frame_start_o,
    input timing_cfg_t cfg
);

    p_frame_with_line_r9: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start_o |-> line_start_o);

    p_strobe_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        line_start_o |=> !line_start_o);

    p_stop_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (hs == H_IDLE && vs == V_IDLE && !de_o));

    p_de_off_line_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
        de_o |-> !line_start_o);

    p_frame_in_vsync_r3: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start_o |-> (vs == V_SYNC && hs == H_SYNC));

    p_cfg_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !load) |=> $stable(cfg));

endmodule

bind lcd_raster_timer lcd_raster_timer_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .run           (run),
    .load          (frame_bound),
    .hs            (h_state),
    .vs            (v_state),
    .de_o          (de_o),
    .line_start_o  (line_start_o),
    .frame_start_o (frame_start_o),
    .cfg           (cfg)
);

// File: tb/lcd_raster_timer_tb.sv
`timescale 1ns/1ps
module lcd_raster_timer_tb;

    typedef struct packed {
        int div; int hsw; int hbp; int hfp; int ppl;
        int vsw; int vbp; int vfp; int lpp;
        int pol; int edg; int exp_cyc;
    } vec_t;

    // pol: [2] pixel, [1] line, [0] frame inversion; edg: 0 rise, 1 fall, 2 select bit only
    localparam vec_t VECS [4] = '{
        '{4, 1, 2, 3, 0,  0, 1, 1, 2,    0, 0, 800},
        '{0, 0, 0, 0, 1,  1, 0, 2, 3,    7, 0, 700},
        '{3, 5, 1, 1, 64, 0, 0, 0, 0,    2, 1, 12600},
        '{2, 0, 0, 0, 0,  0, 0, 0, 1024, 4, 2, 39064}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = '0;
    logic [31:0] wr_data = '0;
    logic pix_clk_o, line_clk_o, frame_clk_o, de_o, line_start_o, frame_start_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    lcd_raster_timer u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .pix_clk_o(pix_clk_o), .line_clk_o(line_clk_o), .frame_clk_o(frame_clk_o),
        .de_o(de_o), .line_start_o(line_start_o), .frame_start_o(frame_start_o)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [31:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_fs();
        while (!frame_start_o) @(negedge clk);
    endtask

    function automatic logic [31:0] hword(input int bp, input int fp, input int sw, input int ppl);
        return (32'(bp) << 24) | (32'(fp) << 16) | (32'(sw) << 10)
             | (32'(ppl & 63) << 4) | (32'((ppl >> 6) & 1) << 3);
    endfunction

    task automatic run_vector(input vec_t v);
        int d, half, h, vt, cyc, ls, dec, hsc, vsc, phc, pix_at_fs, ls_at_fs;
        bit ip, il, ifr, fall;
        ip = v.pol[2]; il = v.pol[1]; ifr = v.pol[0];
        fall = (v.edg == 1);
        d = (v.div < 2) ? 2 : v.div;
        half = d / 2;
        h = (v.hsw + 1) + (v.hbp + 1) + 16 * (v.ppl + 1) + (v.hfp + 1);
        vt = (v.vsw + 1) + (v.vbp + 1) + (v.lpp + 1) + (v.vfp + 1);
        wr(3'd1, 32'd0);
        wr(3'd0, (32'(v.div) << 8) | 32'd1);
        wr(3'd2, hword(v.hbp, v.hfp, v.hsw, v.ppl));
        wr(3'd3, (32'(v.vbp) << 24) | (32'(v.vfp) << 16) | (32'(v.vsw) << 10) | 32'(v.lpp & 1023));
        wr(3'd4, (32'((v.lpp >> 10) & 1) << 26) | (32'(v.edg == 1) << 25) | (32'(v.edg != 0) << 24)
               | (32'(ip) << 22) | (32'(il) << 21) | (32'(ifr) << 20));
        @(negedge clk);
        // R6 / R8: stopped outputs rest at the programmed inactive levels
        check("R6 idle levels", {pix_clk_o, line_clk_o, frame_clk_o, de_o}, {ip, il, ifr, 1'b0});
        wr(3'd1, 32'd1);
        wait_fs();
        cyc = 0; ls = 0; dec = 0; hsc = 0; vsc = 0; phc = 0;
        pix_at_fs = pix_clk_o ^ ip;
        ls_at_fs = line_start_o;
        do begin
            cyc++;
            if (line_start_o) ls++;
            if (de_o) dec++;
            if (line_clk_o ^ il) hsc++;
            if (frame_clk_o ^ ifr) vsc++;
            if (pix_clk_o ^ ip) phc++;
            @(negedge clk);
        end while (!frame_start_o);
        check("R2 frame length", cyc, v.exp_cyc);
        check("R2 frame length formula", cyc, d * h * vt);
        check("R3 lines per frame", ls, vt);
        check((v.ppl > 63 || v.lpp > 1023) ? "R5 extended active area" : "R4 active area",
              dec, d * 16 * (v.ppl + 1) * (v.lpp + 1));
        check("R2 line clock active cycles", hsc, d * (v.hsw + 1) * vt);
        check("R3 frame clock active cycles", vsc, d * h * (v.vsw + 1));
        check("R1 pixel clock high cycles", phc, half * h * vt);
        check("R7 pixel level at frame strobe", pix_at_fs, fall ? 0 : 1);
        check("R9 line strobe with frame strobe", ls_at_fs, 1);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int cyc, act_cnt;
        repeat (3) @(negedge clk);
        // R11: reset state
        check("R11 outputs after reset",
              {pix_clk_o, line_clk_o, frame_clk_o, de_o, line_start_o, frame_start_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 outputs after reset release",
              {pix_clk_o, line_clk_o, frame_clk_o, de_o, line_start_o, frame_start_o}, 0);

        for (int i = 0; i < 4; i++) run_vector(VECS[i]);

        // R10: write during a frame applies at the next frame
        run_vector(VECS[0]);
        wait_fs();
        cyc = 0;
        wr_en = 1'b1; wr_sel = 3'd2; wr_data = hword(2, 8, 1, 0);
        do begin
            cyc++;
            @(negedge clk);
            wr_en = 1'b0;
        end while (!frame_start_o);
        check("R10 running frame keeps old timing", cyc, 800);
        cyc = 0;
        do begin
            cyc++;
            @(negedge clk);
        end while (!frame_start_o);
        check("R10 next frame uses new timing", cyc, 960);

        // R8: mode bit cleared stops the raster
        wr(3'd0, 32'd4 << 8);
        @(negedge clk);
        act_cnt = 0;
        for (int k = 0; k < 40; k++) begin
            if (pix_clk_o | line_clk_o | frame_clk_o | de_o | line_start_o | frame_start_o) act_cnt++;
            @(negedge clk);
        end
        check("R8 mode bit clear holds outputs idle", act_cnt, 0);
        wr(3'd0, (32'd4 << 8) | 32'd1);
        act_cnt = 0;
        for (int k = 0; k < 20; k++) begin
            if (frame_start_o) act_cnt++;
            @(negedge clk);
        end
        check("R8 restart begins a frame", act_cnt, 1);
        wr(3'd1, 32'd0);
        @(negedge clk);
        act_cnt = 0;
        for (int k = 0; k < 40; k++) begin
            if (pix_clk_o | line_clk_o | frame_clk_o | de_o | line_start_o | frame_start_o) act_cnt++;
            @(negedge clk);
        end
        check("R8 enable clear holds outputs idle", act_cnt, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule